// File: doc/BRIEF.md
# Double-Buffered Multi-Mode PWM Channel

This block generates one pulse-width-modulated output from a 16-bit counter. Software may write a period value and a duty value at any moment. The writes land in holding (shadow) registers. The values the counter actually compares against are refreshed from those holding registers only when the channel starts or when the count returns to zero at a period boundary. Because of this, a period that is already under way is never cut short or stretched by a write.

The duty value marks where the off-phase ends. The output stays low while the count is below it and goes high once the count has reached it. Four modes are selectable, and the mode is latched when the channel starts:
- Edge mode: the count ramps up and wraps to zero.
- Centre mode: the count ramps up and then back down.
- Burst mode: edge timing, with the output gated by another channel's output.
- Single-shot mode: edge timing for exactly one period, after which the channel halts.

The count advances either on every clock or once every 64 clocks. A one-clock interrupt pulse marks the start of each new period.

The sequencer has four states. IDLE moves to UP when run is high ("start"). UP moves to DOWN at the period value in centre mode ("turn"). DOWN moves to UP when the count returns to zero ("centre wrap"). In edge, burst and single-shot modes UP stays in UP and clears the count ("edge wrap"); in single-shot mode the same wrap moves UP to DONE instead ("finish"). Any state falls back to IDLE when run is low ("stop").

Top module: `pwm_channel`

## Requirements
- R1: A write to `period_din` or `width_din` while running changes nothing until the count next wraps to 0. The new values take effect at that wrap, and also at a start from IDLE.
- R2: In edge mode (`mode`=2'b00), with active period P, the count goes 0,1,…,P and then wraps to 0, so one period lasts P+1 count steps. The count never exceeds P.
- R3: `pwm_out` is low while count < W and high while count >= W, where W is the active width. A width above the period keeps `pwm_out` low for the whole period.
- R4: In centre mode (`mode`=2'b01), with P >= 2, the count goes 0,1,…,P,P-1,…,1 and then back to 0, so one period lasts 2P steps. The output uses the same comparison as R3.
- R5: With `div_sel`=1 the count advances once every 64 clocks. The first step comes 64 clocks after the first counting clock. With `div_sel`=0 it advances every clock.
- R6: `period_irq` is high for exactly one clock, in the same cycle that the count becomes 0 at a wrap, and only when `irq_en`=1. It never rises at a start.
- R7: In burst mode (`mode`=2'b10) the output is the edge-mode output ANDed with `burst_gate`, combinationally and without delay.
- R8: In single-shot mode (`mode`=2'b11) the channel runs one period and then enters DONE: `running`=0, count 0, `pwm_out` low, and no interrupt. It stays in DONE until `run` is dropped, and a later rise of `run` starts it afresh.
- R9: `pwm_out` is low whenever `out_en`=0 or the channel is not running. `run`=0 returns the channel to IDLE with count 0 at the next clock.
- R10: After reset the channel is IDLE: count 0, `pwm_out`, `period_irq` and `running` all low, and both shadow values 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Level: high runs the channel, low stops it |
| out_en | input | 1 | Output enable; low forces `pwm_out` low |
| irq_en | input | 1 | Enables the period interrupt pulse |
| mode | input | 2 | 00 edge, 01 centre, 10 burst, 11 single-shot (latched at start) |
| div_sel | input | 1 | 0: step every clock, 1: step every 64 clocks |
| period_wr | input | 1 | Writes `period_din` into the period shadow |
| period_din | input | 16 | Period value |
| width_wr | input | 1 | Writes `width_din` into the width shadow |
| width_din | input | 16 | Duty (off-phase length) value |
| burst_gate | input | 1 | Another channel's output, used as a gate in burst mode |
| pwm_out | output | 1 | PWM output |
| period_irq | output | 1 | One-clock pulse at each new period |
| running | output | 1 | High in UP or DOWN |
| count_out | output | 16 | Current count |

## Verification
The count, `running` and `period_irq` all come from one register stage. The count therefore reads 0 one clock after `run` rises, and k-1 after k clocks when dividing by 1. The interrupt appears in the same cycle as the zero count at a wrap.

`pwm_out` is combinational from registered state, so it follows the count in that same cycle. It also follows `burst_gate` and `out_en` without delay.

The bench drives every input on the falling edge and checks on the next falling edge, or 1 ns after a change for the combinational paths. Each expected value is tied to a clock count taken from the start.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        MODE_EDGE   = 2'b00,
        MODE_CENTRE = 2'b01,
        MODE_BURST  = 2'b10,
        MODE_SINGLE = 2'b11
    } pwm_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_DOWN = 2'b10,
        ST_DONE = 2'b11
    } pwm_state_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic div_sel,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || !div_sel)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + DW'(1);
    end

    always_comb begin
        tick = !clear && (!div_sel || cnt == LAST);
    end
endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          irq_en,
    input  pwm_mode_e     mode_in,
    input  logic [CW-1:0] period_sh,
    input  logic [CW-1:0] width_sh,
    output pwm_state_e    state,
    output logic [CW-1:0] count,
    output logic [CW-1:0] period_act,
    output logic [CW-1:0] width_act,
    output pwm_mode_e     mode_act,
    output logic          irq
);
    localparam logic [CW-1:0] ONE = CW'(1);

    pwm_state_e    state_n;
    logic [CW-1:0] count_n;
    logic          start;
    logic          wrap;
    logic          load;

    always_comb begin
        state_n = state;
        count_n = count;
        start   = 1'b0;
        wrap    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    state_n = ST_UP;
                    count_n = '0;
                    start   = 1'b1;
                end
            end
            ST_UP: begin
                if (!run) begin
                    state_n = ST_IDLE;
                    count_n = '0;
                end else if (tick) begin
                    if (count != period_act) begin
                        count_n = count + ONE;
                    end else if (mode_act == MODE_CENTRE && period_act > ONE) begin
                        state_n = ST_DOWN;
                        count_n = count - ONE;
                    end else begin
                        count_n = '0;
                        wrap    = 1'b1;
                        if (mode_act == MODE_SINGLE)
                            state_n = ST_DONE;
                    end
                end
            end
            ST_DOWN: begin
                if (!run) begin
                    state_n = ST_IDLE;
                    count_n = '0;
                end else if (tick) begin
                    if (count <= ONE) begin
                        state_n = ST_UP;
                        count_n = '0;
                        wrap    = 1'b1;
                    end else begin
                        count_n = count - ONE;
                    end
                end
            end
            ST_DONE: begin
                count_n = '0;
                if (!run)
                    state_n = ST_IDLE;
            end
        endcase
        load = start || (wrap && state_n != ST_DONE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // count, active copies and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            period_act <= '0;
            width_act  <= '0;
            mode_act   <= MODE_EDGE;
            irq        <= 1'b0;
        end else begin
            count <= count_n;
            irq   <= irq_en && wrap && state_n != ST_DONE;
            if (load) begin
                period_act <= period_sh;
                width_act  <= width_sh;
            end
            if (start)
                mode_act <= mode_in;
        end
    end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          active,
    input  logic          out_en,
    input  logic          burst_gate,
    input  pwm_mode_e     mode_act,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] width_act,
    output logic          pwm_out
);
    logic on_phase;
    logic gate_ok;

    always_comb begin
        on_phase = count >= width_act;
        gate_ok  = (mode_act != MODE_BURST) || burst_gate;
        pwm_out  = active && out_en && on_phase && gate_ok;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DIV = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          out_en,
    input  logic          irq_en,
    input  logic [1:0]    mode,
    input  logic          div_sel,
    input  logic          period_wr,
    input  logic [CW-1:0] period_din,
    input  logic          width_wr,
    input  logic [CW-1:0] width_din,
    input  logic          burst_gate,
    output logic          pwm_out,
    output logic          period_irq,
    output logic          running,
    output logic [CW-1:0] count_out
);
    logic [CW-1:0] period_sh;
    logic [CW-1:0] width_sh;
    logic [CW-1:0] period_act;
    logic [CW-1:0] width_act;
    logic [CW-1:0] count;
    pwm_state_e    state;
    pwm_mode_e     mode_act;
    logic          tick;
    logic          halted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_sh <= '0;
            width_sh  <= '0;
        end else begin
            if (period_wr) period_sh <= period_din;
            if (width_wr)  width_sh  <= width_din;
        end
    end

    always_comb begin
        halted    = (state == ST_IDLE) || (state == ST_DONE);
        running   = !halted;
        count_out = count;
    end

    pwm_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (halted),
        .div_sel (div_sel),
        .tick    (tick)
    );

    pwm_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .irq_en     (irq_en),
        .mode_in    (pwm_mode_e'(mode)),
        .period_sh  (period_sh),
        .width_sh   (width_sh),
        .state      (state),
        .count      (count),
        .period_act (period_act),
        .width_act  (width_act),
        .mode_act   (mode_act),
        .irq        (period_irq)
    );

    pwm_outstage #(.CW(CW)) u_out (
        .active     (running),
        .out_en     (out_en),
        .burst_gate (burst_gate),
        .mode_act   (mode_act),
        .count      (count),
        .width_act  (width_act),
        .pwm_out    (pwm_out)
    );
endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          out_en,
    input logic          tick,
    input pwm_state_e    state,
    input logic [CW-1:0] count,
    input logic [CW-1:0] period_act,
    input logic          pwm_out,
    input logic          period_irq,
    input logic          running
);
    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> count <= period_act);

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UP && run && tick && count < period_act) |=> count == $past(count) + CW'(1));

    // R1
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count != '0) |-> $stable(period_act));

    // R6
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> (count == '0 && running));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (!pwm_out && count == '0 && !period_irq));

    // R9
    oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en || !running) |-> !pwm_out);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_IDLE && count == '0));
endmodule

bind pwm_channel pwm_channel_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .out_en     (out_en),
    .tick       (tick),
    .state      (state),
    .count      (count),
    .period_act (period_act),
    .pwm_out    (pwm_out),
    .period_irq (period_irq),
    .running    (running)
);

// File: tb/pwm_channel_bench.sv
module pwm_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        out_en = 1'b1;
    logic        irq_en = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        div_sel = 1'b0;
    logic        period_wr = 1'b0;
    logic [15:0] period_din = '0;
    logic        width_wr = 1'b0;
    logic [15:0] width_din = '0;
    logic        burst_gate = 1'b0;
    logic        pwm_out;
    logic        period_irq;
    logic        running;
    logic [15:0] count_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_channel u_pwm_channel (
        .clk(clk), .rst_n(rst_n), .run(run), .out_en(out_en), .irq_en(irq_en),
        .mode(mode), .div_sel(div_sel), .period_wr(period_wr), .period_din(period_din),
        .width_wr(width_wr), .width_din(width_din), .burst_gate(burst_gate),
        .pwm_out(pwm_out), .period_irq(period_irq), .running(running), .count_out(count_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setup(input int p, input int w, input logic [1:0] m, input logic dsel);
        run = 1'b0;
        step();
        mode = m; div_sel = dsel;
        period_wr = 1'b1; period_din = 16'(p);
        width_wr = 1'b1; width_din = 16'(w);
        step();
        period_wr = 1'b0; width_wr = 1'b0;
        run = 1'b1;
    endtask

    task automatic t_reset();
        chk("R10 count", int'(count_out), 0);
        chk("R10 out", int'(pwm_out), 0);
        chk("R10 irq", int'(period_irq), 0);
        chk("R10 running", int'(running), 0);
    endtask

    task automatic t_edge();
        int c;
        irq_en = 1'b1; out_en = 1'b1;
        setup(4, 2, 2'b00, 1'b0);
        for (int k = 1; k <= 12; k++) begin
            step();
            c = (k - 1) % 5;
            chk("R2 edge count", int'(count_out), c);
            chk("R3 edge out", int'(pwm_out), (c >= 2) ? 1 : 0);
            chk("R6 edge irq", int'(period_irq), (k > 1 && c == 0) ? 1 : 0);
        end
    endtask

    task automatic t_over();
        setup(3, 5, 2'b00, 1'b0);
        for (int k = 1; k <= 10; k++) begin
            step();
            chk("R3 width over period", int'(pwm_out), 0);
        end
    endtask

    task automatic t_shadow();
        setup(4, 0, 2'b00, 1'b0);
        for (int k = 1; k <= 9; k++) begin
            step();
            if (k == 2) begin period_wr = 1'b1; period_din = 16'd2; end
            if (k == 3) period_wr = 1'b0;
            if (k == 5) chk("R1 old period kept", int'(count_out), 4);
            if (k == 6) chk("R1 wrap", int'(count_out), 0);
            if (k == 8) chk("R1 new period top", int'(count_out), 2);
            if (k == 9) chk("R1 new period wrap", int'(count_out), 0);
        end
    endtask

    task automatic t_centre();
        int m;
        int c;
        irq_en = 1'b1;
        setup(3, 2, 2'b01, 1'b0);
        for (int k = 1; k <= 13; k++) begin
            step();
            m = (k - 1) % 6;
            c = (m <= 3) ? m : 6 - m;
            chk("R4 centre count", int'(count_out), c);
            chk("R4 centre out", int'(pwm_out), (c >= 2) ? 1 : 0);
            chk("R6 centre irq", int'(period_irq), (k > 1 && m == 0) ? 1 : 0);
        end
    endtask

    task automatic t_irq_off();
        irq_en = 1'b0;
        setup(2, 0, 2'b00, 1'b0);
        for (int k = 1; k <= 8; k++) begin
            step();
            chk("R6 irq disabled", int'(period_irq), 0);
        end
        irq_en = 1'b1;
    endtask

    task automatic t_prescale();
        setup(3, 0, 2'b00, 1'b1);
        for (int k = 1; k <= 129; k++) begin
            step();
            if (k == 64)  chk("R5 before first step", int'(count_out), 0);
            if (k == 65)  chk("R5 first step", int'(count_out), 1);
            if (k == 128) chk("R5 hold", int'(count_out), 1);
            if (k == 129) chk("R5 second step", int'(count_out), 2);
        end
        div_sel = 1'b0;
    endtask

    task automatic t_burst();
        setup(3, 0, 2'b10, 1'b0);
        burst_gate = 1'b0;
        step();
        #1 chk("R7 gate low", int'(pwm_out), 0);
        burst_gate = 1'b1;
        #1 chk("R7 gate high", int'(pwm_out), 1);
        burst_gate = 1'b0;
        #1 chk("R7 gate low again", int'(pwm_out), 0);
    endtask

    task automatic t_single();
        irq_en = 1'b1;
        setup(2, 1, 2'b11, 1'b0);
        for (int k = 1; k <= 7; k++) begin
            step();
            if (k <= 3) begin
                chk("R8 single count", int'(count_out), k - 1);
                chk("R8 single out", int'(pwm_out), (k >= 2) ? 1 : 0);
                chk("R8 single running", int'(running), 1);
            end else begin
                chk("R8 done running", int'(running), 0);
                chk("R8 done count", int'(count_out), 0);
                chk("R8 done out", int'(pwm_out), 0);
                chk("R8 done irq", int'(period_irq), 0);
            end
        end
        run = 1'b0;
        step();
        chk("R8 back to idle", int'(running), 0);
        run = 1'b1;
        step();
        chk("R8 restart running", int'(running), 1);
        chk("R8 restart count", int'(count_out), 0);
    endtask

    task automatic t_oe();
        out_en = 1'b0;
        setup(3, 0, 2'b00, 1'b0);
        for (int k = 1; k <= 6; k++) begin
            step();
            chk("R9 out_en low", int'(pwm_out), 0);
        end
        out_en = 1'b1;
        #1 chk("R9 out_en high", int'(pwm_out), 1);
        run = 1'b0;
        step();
        chk("R9 stop running", int'(running), 0);
        chk("R9 stop count", int'(count_out), 0);
        chk("R9 stop out", int'(pwm_out), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_edge();
        t_over();
        t_shadow();
        t_centre();
        t_irq_off();
        t_prescale();
        t_burst();
        t_single();
        t_oe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule